// File: doc/BRIEF.md
# Seven-Segment Digit Row with Zero Blanking

This block turns a row of 4-bit decimal digits (weights 8, 4, 2, 1) into active-low seven-segment drive for each digit, with no clock and no storage. Each digit position has its own decoder cell. A shared lamp-test input lights every segment so that a display can be inspected. A per-digit blank input turns one position fully dark.

The cells are chained by a zero-blank signal. A cell receives a "suppress" request from its neighbour. If that request is present, its own digit is zero and lamp test is idle, the cell goes dark and passes the request on to the next cell. A parameter sets the direction of the chain. Running from the most significant digit downward hides leading zeros. Running from the least significant digit upward hides trailing zeros. The request at the head of the chain comes in on a port, so suppression can also be switched off as a whole.

Top module: `seg7_row`

## Requirements
- R1: Segment bus digit k occupies seg_n[7k+6:7k] with bit 0 = segment a through bit 6 = segment g, and 0 lights a segment. An unsuppressed digit 0..9 shows the standard glyph: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=all, 9=abcdfg.
- R2: Input codes 10 to 15 drive all seven segments of that digit dark (7'h7F).
- R3: With lt_n low, every digit whose bi_n bit is high lights all segments (7'h00), whatever its code or the chain state.
- R4: A low bi_n bit darkens that digit (7'h7F) regardless of lt_n, the code and the chain, and does not change any rbo_n bit.
- R5: A cell blanks its digit and drives its rbo_n bit low exactly when its incoming suppress request is low, its code is 0 and lt_n is high. Otherwise its rbo_n bit is high.
- R6: With LEAD_FIRST=1 the head request rbi_end_n feeds the most significant digit, and each lower digit takes the rbo_n of the digit above. With rbi_end_n low, digits 0,0,3,0 (MSD first) show blank, blank, 3, 0.
- R7: With LEAD_FIRST=0 rbi_end_n feeds digit 0, and each higher digit takes the rbo_n of the digit below. With rbi_end_n low, digits 5,7,0,0 (MSD first) show 5, 7, blank, blank.
- R8: With rbi_end_n high, no digit is zero-suppressed and zeros are displayed.
- R9: While lt_n is low, all rbo_n bits are high, so no suppression spreads during a lamp test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digits_i | input | 4*NDIG | Packed digit codes, digit k in bits [4k+3:4k], digit 0 least significant |
| lt_n | input | 1 | Lamp test, active low, shared by all digits |
| rbi_end_n | input | 1 | Suppress request into the head of the chain, active low |
| bi_n | input | NDIG | Per-digit forced blank, active low |
| seg_n | output | 7*NDIG | Active-low segment drive, digit k in bits [7k+6:7k] |
| rbo_n | output | NDIG | Per-digit "this digit was zero-suppressed" flag, active low |

## Verification
Three controls can be active on the same digit in the same vector: the forced blank, the lamp test and the ripple suppression. The order between them is what decides the output. The bench sweeps every code combination on a four-digit row in both chain directions, then overlays all 16 blank masks together with both lamp-test levels on zero-heavy and out-of-range digit patterns, so that blank, test and suppression hit the same digit at once. Each vector is judged against a bench model that walks the chain digit by digit and applies blank over test over suppression.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_DARK = 7'h7F;
  localparam seg_t SEG_FULL = 7'h00;

  // Active-high glyph, bit0 = a ... bit6 = g; zero for non-decimal codes.
  function automatic seg_t glyph_on(bcd_t code);
    seg_t s;
    case (code)
      4'd0: s = 7'b0111111;
      4'd1: s = 7'b0000110;
      4'd2: s = 7'b1011011;
      4'd3: s = 7'b1001111;
      4'd4: s = 7'b1100110;
      4'd5: s = 7'b1101101;
      4'd6: s = 7'b1111101;
      4'd7: s = 7'b0000111;
      4'd8: s = 7'b1111111;
      4'd9: s = 7'b1101111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction

  function automatic logic is_decimal(bcd_t code);
    return code <= 4'd9;
  endfunction
endpackage

// File: rtl/seg7_glyph.sv
module seg7_glyph
  import seg7_pkg::*;
(
  input  bcd_t code_i,
  output seg_t pat_n_o,
  output logic legal_o
);
  assign legal_o = is_decimal(code_i);
  assign pat_n_o = ~glyph_on(code_i);

  always_comb begin
    if (!legal_o)
      AST_ILLEGAL_DARK: assert (pat_n_o == SEG_DARK); // R2
  end
endmodule

// File: rtl/seg7_cell.sv
module seg7_cell
  import seg7_pkg::*;
(
  input  bcd_t code_i,
  input  logic lt_n,
  input  logic rbi_n,
  input  logic bi_n,
  output seg_t seg_n,
  output logic rbo_n
);
  seg_t pat_n;
  logic legal;
  logic code_zero;
  logic ripple_hide;
  logic test_on;
  logic forced_off;

  seg7_glyph glyph_i (
    .code_i (code_i),
    .pat_n_o(pat_n),
    .legal_o(legal)
  );

  assign code_zero   = (code_i == '0);
  assign test_on     = !lt_n;
  assign forced_off  = !bi_n;
  assign ripple_hide = !rbi_n && code_zero && !test_on;
  assign rbo_n       = !ripple_hide;

  // Priority: forced blank, then lamp test, then ripple blank, then glyph.
  always_comb begin
    if (forced_off)       seg_n = SEG_DARK;
    else if (test_on)     seg_n = SEG_FULL;
    else if (ripple_hide) seg_n = SEG_DARK;
    else                  seg_n = pat_n;
  end

  always_comb begin
    if (forced_off)
      AST_BLANK_WINS: assert (seg_n == SEG_DARK); // R4
    if (bi_n && test_on)
      AST_TEST_ALL_ON: assert (seg_n == SEG_FULL); // R3
    if (!rbo_n)
      AST_RBO_NEEDS_ZERO: assert (code_i == '0 && !rbi_n && lt_n); // R5
    if (test_on)
      AST_TEST_HOLDS_RBO: assert (rbo_n); // R9
    if (!rbo_n && bi_n)
      AST_HIDDEN_DARK: assert (seg_n == SEG_DARK); // R5
    if (bi_n && lt_n && rbo_n && legal)
      AST_SHOWN_GLYPH: assert (seg_n != SEG_DARK); // R1
  end
endmodule

// File: rtl/seg7_row.sv
module seg7_row
  import seg7_pkg::*;
#(
  parameter int NDIG       = 4,
  parameter bit LEAD_FIRST = 1'b1
) (
  input  logic [NDIG*4-1:0] digits_i,
  input  logic              lt_n,
  input  logic              rbi_end_n,
  input  logic [NDIG-1:0]   bi_n,
  output logic [NDIG*7-1:0] seg_n,
  output logic [NDIG-1:0]   rbo_n
);
  localparam int DW   = NDIG * BCD_W;
  localparam int SW   = NDIG * SEG_W;
  localparam int HEAD = LEAD_FIRST ? NDIG - 1 : 0;

  logic [NDIG-1:0] rbi_w;

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    if (k == HEAD) begin : g_head
      assign rbi_w[k] = rbi_end_n;
    end else if (LEAD_FIRST) begin : g_from_above
      assign rbi_w[k] = rbo_n[k+1];
    end else begin : g_from_below
      assign rbi_w[k] = rbo_n[k-1];
    end

    seg7_cell cell_i (
      .code_i(digits_i[k*BCD_W +: BCD_W]),
      .lt_n  (lt_n),
      .rbi_n (rbi_w[k]),
      .bi_n  (bi_n[k]),
      .seg_n (seg_n[k*SEG_W +: SEG_W]),
      .rbo_n (rbo_n[k])
    );
  end

  // A suppressed digit implies every digit from the head to it is zero.
  always_comb begin
    for (int k = 0; k < NDIG; k++) begin
      for (int j = 0; j < NDIG; j++) begin
        if (LEAD_FIRST && !rbo_n[k] && j >= k)
          AST_LEAD_ZEROS: assert (digits_i[j*BCD_W +: BCD_W] == '0 && !rbi_end_n); // R6
        if (!LEAD_FIRST && !rbo_n[k] && j <= k)
          AST_TRAIL_ZEROS: assert (digits_i[j*BCD_W +: BCD_W] == '0 && !rbi_end_n); // R7
      end
    end
    if (rbi_end_n)
      AST_NO_REQ_NO_HIDE: assert (&rbo_n); // R8
  end

  logic unused_w;
  assign unused_w = ^{DW[0], SW[0]};
endmodule

// File: tb/seg7_row_tb_top.sv
`timescale 1ns/1ps
module seg7_row_tb_top;
  logic        clk = 1'b0;
  logic [15:0] digits;
  logic        lt_n;
  logic        rbi_end_n;
  logic [3:0]  bi_n;
  logic [27:0] seg_lead, seg_trail;
  logic [3:0]  rbo_lead, rbo_trail;
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always #2.5 clk = ~clk;

  seg7_row #(.NDIG(4), .LEAD_FIRST(1'b1)) dut_i (
    .digits_i(digits), .lt_n(lt_n), .rbi_end_n(rbi_end_n), .bi_n(bi_n),
    .seg_n(seg_lead), .rbo_n(rbo_lead));

  seg7_row #(.NDIG(4), .LEAD_FIRST(1'b0)) dut_trail_i (
    .digits_i(digits), .lt_n(lt_n), .rbi_end_n(rbi_end_n), .bi_n(bi_n),
    .seg_n(seg_trail), .rbo_n(rbo_trail));

  // Segment lit rules written per segment (bit0=a .. bit6=g).
  function automatic logic [6:0] lit_of(logic [3:0] d);
    logic [6:0] s;
    if (d > 4'd9) return 7'h00;
    s[0] = !(d == 1 || d == 4);
    s[1] = !(d == 5 || d == 6);
    s[2] = (d != 2);
    s[3] = !(d == 1 || d == 4 || d == 7);
    s[4] = (d == 0 || d == 2 || d == 6 || d == 8);
    s[5] = !(d == 1 || d == 2 || d == 3 || d == 7);
    s[6] = !(d == 0 || d == 1 || d == 7);
    return s;
  endfunction

  task automatic model(input logic [15:0] dg, input logic lt, input logic [3:0] bi,
                       input logic rbi, input bit lead,
                       output logic [27:0] seg, output logic [3:0] rbo);
    bit carry = !rbi;
    for (int k = 0; k < 4; k++) begin
      int i = lead ? 3 - k : k;
      logic [3:0] d = dg[i*4 +: 4];
      bit sup = carry && (d == 4'd0) && lt;
      rbo[i] = !sup;
      carry = sup;
      if (!bi[i])           seg[i*7 +: 7] = 7'h7F;
      else if (!lt)         seg[i*7 +: 7] = 7'h00;
      else if (sup)         seg[i*7 +: 7] = 7'h7F;
      else                  seg[i*7 +: 7] = ~lit_of(d);
    end
  endtask

  task automatic apply_and_check(input logic [15:0] dg, input logic lt, input logic [3:0] bi,
                                 input logic rbi, input string tag_lead, input string tag_trail);
    logic [27:0] es;
    logic [3:0]  er;
    @(negedge clk);
    digits = dg; lt_n = lt; bi_n = bi; rbi_end_n = rbi;
    @(posedge clk);
    #1;
    model(dg, lt, bi, rbi, 1'b1, es, er);
    n_chk++;
    if (seg_lead !== es || rbo_lead !== er) begin
      n_fail++;
      $display("FAIL %s lead digits=%h: seg=%h rbo=%b expected seg=%h rbo=%b",
               tag_lead, dg, seg_lead, rbo_lead, es, er);
    end
    model(dg, lt, bi, rbi, 1'b0, es, er);
    n_chk++;
    if (seg_trail !== es || rbo_trail !== er) begin
      n_fail++;
      $display("FAIL %s trail digits=%h: seg=%h rbo=%b expected seg=%h rbo=%b",
               tag_trail, dg, seg_trail, rbo_trail, es, er);
    end
  endtask

  task automatic direct(input string tag, input logic [27:0] act, input logic [27:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp_v);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    digits = '0; lt_n = 1'b1; bi_n = 4'hF; rbi_end_n = 1'b1;
    repeat (2) @(posedge clk);

    // Initial state, all zeros without suppression request: R8
    apply_and_check(16'h0000, 1'b1, 4'hF, 1'b1, "R8 reset", "R8 reset");

    // Named chain examples: R6 leading 0030, R7 trailing 5700
    apply_and_check(16'h0030, 1'b1, 4'hF, 1'b0, "R6", "R7");
    direct("R6 0030 lead", seg_lead,
           {7'h7F, 7'h7F, ~lit_of(4'd3), ~lit_of(4'd0)});
    apply_and_check(16'h5700, 1'b1, 4'hF, 1'b0, "R6", "R7");
    direct("R7 5700 trail", seg_trail,
           {~lit_of(4'd5), ~lit_of(4'd7), 7'h7F, 7'h7F});
    direct("R1 glyph 8 all on", {21'h0, ~lit_of(4'd8)}, {21'h0, 7'h00});

    // Exhaustive codes with suppression requested: R1 R2 R5 R6 R7
    for (int v = 0; v < 65536; v++)
      apply_and_check(16'(v), 1'b1, 4'hF, 1'b0, "R1 R2 R5 R6", "R1 R2 R5 R7");

    // Suppression not requested: R8 R1 R2
    for (int v = 0; v < 65536; v += 7)
      apply_and_check(16'(v), 1'b1, 4'hF, 1'b1, "R8 R1 R2", "R8 R1 R2");

    // Lamp test across patterns: R3 R9
    for (int v = 0; v < 65536; v += 251)
      apply_and_check(16'(v), 1'b0, 4'hF, 1'b0, "R3 R9", "R3 R9");

    // Forced blank overlaid on test and suppression: R4 R3 R5
    for (int m = 0; m < 16; m++) begin
      for (int t = 0; t < 2; t++) begin
        apply_and_check(16'h0000, 1'(t), 4'(m), 1'b0, "R4", "R4");
        apply_and_check(16'h0030, 1'(t), 4'(m), 1'b0, "R4", "R4");
        apply_and_check(16'h5700, 1'(t), 4'(m), 1'b0, "R4", "R4");
        apply_and_check(16'hA0F9, 1'(t), 4'(m), 1'b0, "R4 R2", "R4 R2");
        apply_and_check(16'h0102, 1'(t), 4'(m), 1'b1, "R4 R8", "R4 R8");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule